// File: doc/BRIEF.md
# Open-Drain Capable GPIO Port

An eight-pin general-purpose I/O port with a small register bus. Software selects for each pin whether it is an input or an output, sets the value driven on output pins, and chooses per pin between push-pull and open-drain driving. The block produces an output value and an output enable for each tri-state pad. It brings pin levels into the clock domain through a two-flop synchronizer and returns them on reads. The synchronized levels of the top four pins also go out as interrupt request lines.

Open-drain selection applies only while the single-chip mode input is high. Otherwise every pin drives push-pull. The open-drain register survives a manual reset and software standby. A power-on reset or hardware standby clears it. A manual reset clears the direction and data registers. While either standby input is high, all register writes are dropped.

Top module: `gpio_od_port`

## Requirements
- R1: After power-on reset (rst_ni low), the direction, data and open-drain registers read 0x00 and every pad output enable is 0.
- R2: Writes take effect at the next clock edge. Address 0 reads back the direction register and address 1 reads back the data register. A direction bit of 1 makes its pin an output.
- R3: Address 2 reads back the open-drain register, which holds all eight bits as written.
- R4: The pad output value always equals the data register. The output enable is 1 only for an output pin that is either push-pull, or open-drain with a data bit of 0. An open-drain pin that drives 1 is released.
- R5: While single_chip_i is 0, the open-drain bits have no effect and every output pin is enabled.
- R6: Address 3 returns the synchronized pin level for input pins and the data register bit for output pins.
- R7: irq_o[3:0] carries the synchronized levels of pins 7 to 4, whatever the pin direction.
- R8: man_rst_i held high at a clock edge clears the direction and data registers, keeps the open-drain register, and drops any write in that cycle.
- R9: hw_stby_i high at a clock edge clears the open-drain register. sw_stby_i leaves it unchanged. While either standby input is high, writes to any register are dropped.
- R10: A change on a pin shows on address 3 and on irq_o after exactly two clock edges, and not after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, asynchronous, active low |
| man_rst_i | input | 1 | Manual reset, synchronous, active high |
| hw_stby_i | input | 1 | Hardware standby indication |
| sw_stby_i | input | 1 | Software standby indication |
| single_chip_i | input | 1 | Single-chip mode; enables open-drain selection |
| addr_i | input | 2 | Register address: 0 direction, 1 data, 2 open-drain, 3 pin level |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Combinational read data |
| pin_i | input | 8 | Pad input levels |
| pad_out_o | output | 8 | Pad output value |
| pad_oe_o | output | 8 | Pad output enable |
| irq_o | output | 4 | Synchronized levels of pins 7 to 4 |

## Verification
The pad-control function is driven from a table of direction, data, open-drain and mode combinations. All-push-pull rows are set against all-open-drain rows with mixed data, which shows whether released-high pins are told apart from pins driven low. The same register values are then applied with the mode input low, which shows that the open-drain bits are masked. Mixed rows with partial direction show that the direction mask is applied before the open-drain rule. Directed sequences then apply a pin change, read one edge and two edges later to pin down the synchronizer depth, and check each reset and standby input for what it clears and what it keeps.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    REG_DIR  = 2'd0,
    REG_DATA = 2'd1,
    REG_OD   = 2'd2,
    REG_PIN  = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int N_PINS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] dir_q_o,
  output logic [N_PINS-1:0] data_q_o,
  output logic [N_PINS-1:0] od_q_o
);
  logic wr_ok;
  logic wr_dir, wr_data, wr_od;

  // standby and manual reset both block the bus
  assign wr_ok   = we_i & ~sw_stby_i & ~hw_stby_i & ~man_rst_i;
  assign wr_dir  = wr_ok & (gpio_addr_e'(addr_i) == REG_DIR);
  assign wr_data = wr_ok & (gpio_addr_e'(addr_i) == REG_DATA);
  assign wr_od   = wr_ok & (gpio_addr_e'(addr_i) == REG_OD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q_o  <= '0;
      data_q_o <= '0;
    end else if (man_rst_i) begin
      dir_q_o  <= '0;
      data_q_o <= '0;
    end else begin
      if (wr_dir)  dir_q_o  <= wdata_i;
      if (wr_data) data_q_o <= wdata_i;
    end
  end

  // open-drain select survives manual reset and software standby
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        od_q_o <= '0;
    else if (hw_stby_i) od_q_o <= '0;
    else if (wr_od)     od_q_o <= wdata_i;
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int N_PINS = 8
) (
  input  logic              single_chip_i,
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] data_i,
  input  logic [N_PINS-1:0] od_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o
);
  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic od_eff;
    assign od_eff       = od_i[i] & single_chip_i;
    // open-drain high releases the pad
    assign pad_oe_o[i]  = dir_i[i] & (~od_eff | ~data_i[i]);
    assign pad_out_o[i] = data_i[i];
  end
endmodule

// File: rtl/gpio_od_port.sv
module gpio_od_port
  import gpio_pkg::*;
#(
  parameter int N_PINS      = 8,
  parameter int N_IRQ       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic              hw_stby_i,
  input  logic              sw_stby_i,
  input  logic              single_chip_i,
  input  logic [1:0]        addr_i,
  input  logic              we_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] rdata_o,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pad_out_o,
  output logic [N_PINS-1:0] pad_oe_o,
  output logic [N_IRQ-1:0]  irq_o
);
  localparam int IRQ_LSB = N_PINS - N_IRQ;

  logic [N_PINS-1:0] dir_q, data_q, od_q;
  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] pin_rd;

  gpio_regs #(.N_PINS(N_PINS)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .man_rst_i (man_rst_i),
    .hw_stby_i (hw_stby_i),
    .sw_stby_i (sw_stby_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .dir_q_o   (dir_q),
    .data_q_o  (data_q),
    .od_q_o    (od_q)
  );

  gpio_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio_pad_ctl #(.N_PINS(N_PINS)) u_pad (
    .single_chip_i (single_chip_i),
    .dir_i         (dir_q),
    .data_i        (data_q),
    .od_i          (od_q),
    .pad_out_o     (pad_out_o),
    .pad_oe_o      (pad_oe_o)
  );

  assign pin_rd = (dir_q & data_q) | (~dir_q & pin_sync);
  assign irq_o  = pin_sync[N_PINS-1:IRQ_LSB];

  always_comb begin
    unique case (gpio_addr_e'(addr_i))
      REG_DIR:  rdata_o = dir_q;
      REG_DATA: rdata_o = data_q;
      REG_OD:   rdata_o = od_q;
      default:  rdata_o = pin_rd;
    endcase
  end
endmodule

// File: rtl/gpio_od_port_chk.sv
module gpio_od_port_chk #(
  parameter int N_PINS = 8,
  parameter int N_IRQ  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              man_rst_i,
  input logic              hw_stby_i,
  input logic              sw_stby_i,
  input logic              single_chip_i,
  input logic [N_PINS-1:0] pin_i,
  input logic [N_PINS-1:0] pad_out_o,
  input logic [N_PINS-1:0] pad_oe_o,
  input logic [N_IRQ-1:0]  irq_o,
  input logic [N_PINS-1:0] dir_q,
  input logic [N_PINS-1:0] data_q,
  input logic [N_PINS-1:0] od_q
);
  localparam int IRQ_LSB = N_PINS - N_IRQ;

  logic [1:0] live_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               live_cnt <= '0;
    else if (live_cnt != 2'd3) live_cnt <= live_cnt + 2'd1;
  end

  assert_od_release_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & pad_out_o & od_q & {N_PINS{single_chip_i}}) == '0);

  assert_oe_needs_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pad_oe_o & ~dir_q) == '0);

  assert_pushpull_mode_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !single_chip_i |-> pad_oe_o == dir_q);

  assert_mrst_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rst_i |=> (dir_q == '0 && data_q == '0));

  assert_mrst_keep_od_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (man_rst_i && !hw_stby_i) |=> od_q == $past(od_q));

  assert_hwstby_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> od_q == '0);

  assert_swstby_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_stby_i && !man_rst_i && !hw_stby_i) |=>
      (dir_q == $past(dir_q) && data_q == $past(data_q) && od_q == $past(od_q)));

  assert_irq_lag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_cnt >= 2'd2) |-> irq_o == $past(pin_i[N_PINS-1:IRQ_LSB], 2));
endmodule

bind gpio_od_port gpio_od_port_chk #(.N_PINS(N_PINS), .N_IRQ(N_IRQ)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .man_rst_i     (man_rst_i),
  .hw_stby_i     (hw_stby_i),
  .sw_stby_i     (sw_stby_i),
  .single_chip_i (single_chip_i),
  .pin_i         (pin_i),
  .pad_out_o     (pad_out_o),
  .pad_oe_o      (pad_oe_o),
  .irq_o         (irq_o),
  .dir_q         (dir_q),
  .data_q        (data_q),
  .od_q          (od_q)
);

// File: tb/sim_gpio_od_port.sv
`timescale 1ns/1ps
module sim_gpio_od_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       man_rst_i = 1'b0, hw_stby_i = 1'b0, sw_stby_i = 1'b0;
  logic       single_chip_i = 1'b1;
  logic [1:0] addr_i = 2'd0;
  logic       we_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [7:0] pin_i = 8'h00;
  logic [7:0] pad_out_o, pad_oe_o;
  logic [3:0] irq_o;

  int total = 0;
  int bad = 0;

  always #5 clk_i = ~clk_i;

  gpio_od_port u0 (.*);

  // {dir, data, od, single_chip, exp_oe, exp_out}
  localparam int NV = 6;
  localparam logic [40:0] VEC [NV] = '{
    {8'hFF, 8'h0F, 8'h00, 1'b1, 8'hFF, 8'h0F},
    {8'hFF, 8'h0F, 8'hFF, 1'b1, 8'hF0, 8'h0F},
    {8'hFF, 8'h0F, 8'hFF, 1'b0, 8'hFF, 8'h0F},
    {8'hF0, 8'hAA, 8'h3C, 1'b1, 8'hD0, 8'hAA},
    {8'h00, 8'hFF, 8'hFF, 1'b1, 8'h00, 8'hFF},
    {8'h5A, 8'h33, 8'h0F, 1'b0, 8'h5A, 8'h33}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  initial begin
    #200_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    #23 rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 oe", pad_oe_o, 8'h00);
    rd(2'd0, r); chk("R1 dir", r, 8'h00);
    rd(2'd1, r); chk("R1 data", r, 8'h00);
    rd(2'd2, r); chk("R1 od", r, 8'h00);

    // R2..R5 table walk
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, VEC[v][40:33]);
      wr(2'd1, VEC[v][32:25]);
      wr(2'd2, VEC[v][24:17]);
      single_chip_i = VEC[v][16];
      #1;
      rd(2'd0, r); chk("R2 dir readback", r, VEC[v][40:33]);
      rd(2'd1, r); chk("R2 data readback", r, VEC[v][32:25]);
      rd(2'd2, r); chk("R3 od readback", r, VEC[v][24:17]);
      chk(VEC[v][16] ? "R4 pad oe" : "R5 pad oe", pad_oe_o, VEC[v][15:8]);
      chk("R4 pad out", pad_out_o, VEC[v][7:0]);
    end
    single_chip_i = 1'b1;

    // R6/R10: upper inputs, lower outputs
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'h05);
    pin_i = 8'hA0;
    @(posedge clk_i); @(negedge clk_i);
    rd(2'd3, r); chk("R10 one edge", r, 8'h05);
    chk("R10 irq one edge", {4'h0, irq_o}, 8'h00);
    @(posedge clk_i); @(negedge clk_i);
    rd(2'd3, r); chk("R6 pin read", r, 8'hA5);
    chk("R10 irq two edges", {4'h0, irq_o}, 8'h0A);

    // R7: irq follows pins even when they are outputs
    wr(2'd0, 8'hFF);
    pin_i = 8'h30;
    @(posedge clk_i); @(negedge clk_i);
    @(posedge clk_i); @(negedge clk_i);
    chk("R7 irq on outputs", {4'h0, irq_o}, 8'h03);
    rd(2'd3, r); chk("R6 output pins read data", r, 8'h05);

    // R8 manual reset with a simultaneous write
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'hC3);
    @(negedge clk_i);
    man_rst_i = 1'b1; addr_i = 2'd2; wdata_i = 8'h00; we_i = 1'b1;
    @(negedge clk_i);
    man_rst_i = 1'b0; we_i = 1'b0;
    rd(2'd0, r); chk("R8 dir cleared", r, 8'h00);
    rd(2'd1, r); chk("R8 data cleared", r, 8'h00);
    rd(2'd2, r); chk("R8 od kept", r, 8'hC3);

    // R9 software standby
    sw_stby_i = 1'b1;
    wr(2'd2, 8'h11);
    wr(2'd0, 8'h77);
    sw_stby_i = 1'b0;
    rd(2'd2, r); chk("R9 sw stby od kept", r, 8'hC3);
    rd(2'd0, r); chk("R9 sw stby dir write dropped", r, 8'h00);

    // R9 hardware standby
    hw_stby_i = 1'b1;
    wr(2'd1, 8'h44);
    hw_stby_i = 1'b0;
    rd(2'd2, r); chk("R9 hw stby od cleared", r, 8'h00);
    rd(2'd1, r); chk("R9 hw stby data write dropped", r, 8'h00);

    // R1 power-on reset clears the open-drain register
    wr(2'd2, 8'h5A);
    rst_ni = 1'b0;
    #3 rst_ni = 1'b1;
    rd(2'd2, r); chk("R1 por od cleared", r, 8'h00);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule